// File: doc/BRIEF.md
# Systematic Rate-Half Convolutional Encoder

This block turns a serial bit stream into a rate 1/2 convolutional code with constraint length 6. Each data bit yields two code bits. The first is a straight copy of the data bit (the systematic stream). The second is a parity bit formed from the current bit and the bits that arrived three, four and five data periods earlier. Five memory stages hold that history.

The block runs from one fast clock at twice the data rate. An internal divide-by-two sets the data period, and that period is also driven out as a data clock. The producer changes `din` once per data period, while `dclk` is low. Within each period a 2:1 multiplexer sends the systematic bit and then the parity bit onto one serial line. Every output comes straight from a flip-flop, so glitches from the combining logic never reach a pin.

The code has no built-in termination. A sender ends a message by feeding five zero bits, which returns the memory to the all-zero state.

Top module: `conv_half_encoder`

## Requirements
- R1: At the fast-clock edge that opens a data period (`dclk` low before the edge), `sys_q` takes the value of `din`.
- R2: At that same edge, `par_q` takes `din` XOR the data bits from 3, 4 and 5 periods earlier. This is generator 100111, read from delay 0 to delay 5.
- R3: `ser_q` carries one code bit per fast cycle. After the period-opening edge it shows the systematic bit. After the following edge it shows the parity bit of the same period.
- R4: `dclk` toggles on every fast edge. It is low in the cycle right after reset, and it is high in the second half of each data period.
- R5: A synchronous active-high `rst` clears the memory stages, the divider and all output flip-flops to zero. Bits fed before a reset have no effect on parity bits computed after it.
- R6: After five consecutive zero data bits the memory is all zero. The parity of the next period then equals that period's data bit.
- R7: The data 11010101 followed by five zeros gives systematic bits 1101010100000, parity bits 1100010001011 and serial bits 11110010001100100001000101, earliest bit first.
- R8: `sys_q` and `par_q` change only at period-opening edges. They hold steady across the second half of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at twice the data rate |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, held for one data period |
| dclk | output | 1 | Derived data clock, fast clock divided by two |
| sys_q | output | 1 | Registered systematic code stream |
| par_q | output | 1 | Registered parity code stream |
| ser_q | output | 1 | Serialized code stream, systematic bit first |

## Verification
A corrupt memory stage shows on `par_q` as a wrong parity bit. It appears three to five data periods after the bad bit entered, depending on which stage holds it. It clears only once that bit shifts past delay five, so the bench flushes with zeros and then sends an impulse: any residue shows up against the pure generator response. A slipped divider phase swaps the two bits of each pair on `ser_q` within one fast cycle, and the bench catches this by checking every serial position. A parity fault also shows on `ser_q` in the second half of the same period.

// File: rtl/cenc_pkg.sv
package cenc_pkg;

    localparam int MEM_STAGES = 5;
    localparam int WIN_W      = MEM_STAGES + 1;

    // Parity generator: bit k set means the bit of delay k contributes.
    localparam logic [WIN_W-1:0] PAR_TAPS_DEF = 6'b111001;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic sys;
        logic par;
    } code_pair_t;

endpackage

// File: rtl/cenc_phase.sv
module cenc_phase
    import cenc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_FIRST;
        else     ph_q <= (ph_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
    end

    assign phase = ph_q;

    // R4: the phase alternates on every edge once out of reset
    p_dclk_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ph_q != $past(ph_q)));

    // R4: divider restarts in the first half
    p_dclk_reset_r4: assert property (@(posedge clk)
        rst |=> (ph_q == PH_FIRST));

endmodule

// File: rtl/cenc_memory.sv
module cenc_memory
    import cenc_pkg::*;
#(
    parameter int               MEM  = MEM_STAGES,
    parameter logic [MEM:0]     TAPS = PAR_TAPS_DEF
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       din,
    output code_pair_t pair_n
);

    localparam int CW = $clog2(MEM + 1) + 1;

    logic [MEM:1] s_q;     // s_q[k]: data bit from k periods ago
    logic [MEM:0] window;
    logic [MEM:0] term;

    always_ff @(posedge clk) begin
        if (rst)      s_q <= '0;
        else if (adv) s_q <= {s_q[MEM-1:1], din};
    end

    assign window = {s_q, din};

    for (genvar k = 0; k <= MEM; k++) begin : g_tap
        if (TAPS[k]) begin : g_on
            assign term[k] = window[k];
        end else begin : g_off
            assign term[k] = 1'b0;
        end
    end

    always_comb begin
        pair_n.sys = din;
        pair_n.par = ^term;
    end

    // Run length of zero advances, for the flush check (R6)
    logic [CW-1:0] zrun_q;
    always_ff @(posedge clk) begin
        if (rst) zrun_q <= CW'(MEM);
        else if (adv) begin
            if (din) zrun_q <= '0;
            else if (zrun_q < CW'(MEM)) zrun_q <= zrun_q + 1'b1;
        end
    end

    // R6: five zero inputs leave the memory empty
    p_flush_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (zrun_q == CW'(MEM)) |-> (s_q == '0));

    // R5: reset empties the memory
    p_mem_reset_r5: assert property (@(posedge clk)
        rst |=> (s_q == '0));

endmodule

// File: rtl/cenc_serial.sv
module cenc_serial
    import cenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_e     phase,
    input  code_pair_t pair_n,
    output logic       sys_q,
    output logic       par_q,
    output logic       ser_q
);

    logic ser_d;

    // 2:1 mux at the fast rate: systematic first, parity second
    always_comb begin
        ser_d = (phase == PH_SECOND) ? par_q : pair_n.sys;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_q <= 1'b0;
            par_q <= 1'b0;
            ser_q <= 1'b0;
        end else begin
            if (phase == PH_FIRST) begin
                sys_q <= pair_n.sys;
                par_q <= pair_n.par;
            end
            ser_q <= ser_d;
        end
    end

    // R3: first serial slot carries the systematic bit
    p_ser_first_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FIRST) |=> (ser_q == sys_q));

    // R3: second serial slot carries the parity bit of the same period
    p_ser_second_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SECOND) |=> (ser_q == par_q));

    // R8: code streams hold across the second half
    p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SECOND) |=> ($stable(sys_q) && $stable(par_q)));

    // R5: outputs cleared by reset
    p_out_reset_r5: assert property (@(posedge clk)
        rst |=> (!sys_q && !par_q && !ser_q));

endmodule

// File: rtl/conv_half_encoder.sv
module conv_half_encoder
    import cenc_pkg::*;
#(
    parameter int                 MEM  = MEM_STAGES,
    parameter logic [MEM:0]       TAPS = PAR_TAPS_DEF
)(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dclk,
    output logic sys_q,
    output logic par_q,
    output logic ser_q
);

    phase_e     phase;
    code_pair_t pair_n;

    cenc_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    cenc_memory #(.MEM(MEM), .TAPS(TAPS)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .adv    (phase == PH_FIRST),
        .din    (din),
        .pair_n (pair_n)
    );

    cenc_serial u_ser (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .pair_n (pair_n),
        .sys_q  (sys_q),
        .par_q  (par_q),
        .ser_q  (ser_q)
    );

    assign dclk = (phase == PH_SECOND);

    // R1: systematic output copies the data bit of the period
    p_sys_copy_r1: assert property (@(posedge clk) disable iff (rst)
        !dclk |=> (sys_q == $past(din)));

endmodule

// File: tb/sim_conv_half_encoder.sv
module sim_conv_half_encoder;

    localparam int NVEC = 3;
    localparam int VLEN = 13;
    // Data (earliest bit at MSB) and hand-derived parity per vector
    localparam logic [VLEN-1:0] VIN  [NVEC] = '{13'b1101010100000,
                                               13'b1000000000000,
                                               13'b1111111100000};
    localparam logic [VLEN-1:0] VPAR [NVEC] = '{13'b1100010001011,
                                               13'b1001110000000,
                                               13'b1110100011101};
    localparam logic [25:0] EX_SER = 26'b11110010001100100001000101;
    localparam logic [5:0]  TAPS   = 6'b111001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic dclk, sys_q, par_q, ser_q;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] hist = '0;
    logic [25:0] ser_acc;
    logic [VLEN-1:0] par_acc;

    always #2 clk = ~clk;

    conv_half_encoder u0 (
        .clk(clk), .rst(rst), .din(din),
        .dclk(dclk), .sys_q(sys_q), .par_q(par_q), .ser_q(ser_q)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // One data period; entered and left at a negedge with dclk low
    task automatic period(input logic b, output logic p_out);
        logic ep;
        din = b;
        hist = {hist[4:0], b};
        ep = ^(hist & TAPS);
        @(posedge clk); @(negedge clk);
        check("R1 sys", sys_q, b);
        check("R2 par", par_q, ep);
        check("R3 ser first", ser_q, b);
        check("R4 dclk high", dclk, 1'b1);
        ser_acc = {ser_acc[24:0], ser_q};
        @(posedge clk); @(negedge clk);
        check("R3 ser second", ser_q, ep);
        check("R8 sys hold", sys_q, b);
        check("R8 par hold", par_q, ep);
        check("R4 dclk low", dclk, 1'b0);
        ser_acc = {ser_acc[24:0], ser_q};
        p_out = par_q;
    endtask

    initial begin
        logic p;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5 reset sys", sys_q, 1'b0);
        check("R5 reset par", par_q, 1'b0);
        check("R5 reset ser", ser_q, 1'b0);
        check("R4 reset dclk", dclk, 1'b0);
        rst = 1'b0;

        // Table walk; each vector ends in five zeros (flush, R6)
        for (int v = 0; v < NVEC; v++) begin
            ser_acc = '0;
            par_acc = '0;
            for (int i = VLEN - 1; i >= 0; i--) begin
                period(VIN[v][i], p);
                par_acc = {par_acc[VLEN-2:0], p};
            end
            n_chk++;
            if (par_acc !== VPAR[v]) begin
                n_bad++;
                $display("FAIL R2 vector %0d: got %b expected %b", v, par_acc, VPAR[v]);
            end
            if (v == 0) begin
                n_chk++;
                if (ser_acc !== EX_SER) begin
                    n_bad++;
                    $display("FAIL R7 serial: got %b expected %b", ser_acc, EX_SER);
                end
            end
        end

        // Random stream, then flush and impulse (R6)
        for (int i = 0; i < 60; i++) period(1'($urandom), p);
        for (int i = 0; i < 5; i++) period(1'b0, p);
        period(1'b1, p);
        check("R6 post-flush impulse", p, 1'b1);
        for (int i = 0; i < 5; i++) period(1'b0, p);

        // Reset mid-stream clears history (R5)
        period(1'b1, p); period(1'b1, p); period(1'b1, p);
        din = 1'b1;
        rst = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R5 mid reset sys", sys_q, 1'b0);
        check("R5 mid reset par", par_q, 1'b0);
        check("R5 mid reset ser", ser_q, 1'b0);
        check("R5 mid reset dclk", dclk, 1'b0);
        rst = 1'b0;
        hist = '0;
        par_acc = '0;
        period(1'b1, p); par_acc = {par_acc[VLEN-2:0], p};
        for (int i = 0; i < 5; i++) begin
            period(1'b0, p);
            par_acc = {par_acc[VLEN-2:0], p};
        end
        n_chk++;
        if (par_acc[5:0] !== 6'b100111) begin
            n_bad++;
            $display("FAIL R5 history after reset: got %b expected %b", par_acc[5:0], 6'b100111);
        end

        summary();
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

endmodule